// File: doc/BRIEF.md
# Memory-Based Exchange Sorter

This block holds a small table of K unsigned words in its own single-port memory and puts them into ascending order in place. A host fills the table through a simple write port while the mode input `sort_go` is low. It then raises `sort_go`. The block runs a nested-loop exchange sort over the table and raises `sort_done` when the table is ordered. After the host lowers `sort_go`, the block returns to load mode, and the host reads the ordered words back by address through the same port.

Inside, a controller FSM steps through the sort. A datapath holds the two loop indices, two operand registers, a magnitude comparator and the address and write-data selectors. For every outer index `i`, the word at `i` is captured into operand A. Each later word at `j` is captured into operand B and compared with A. When A is strictly greater than B, the two words are written back exchanged. A is then fetched again from `i`, so that the next comparisons use the new smallest value. Ownership of the memory passes between host and sorter according to the mode input and the controller state.

Top module: `xsort_top`

## Requirements
- R1: While `rst_n` is low and after its release, `sort_done` is 0 and `rd_word` is 0.
- R2: In load mode (`sort_go` low and the block idle), a cycle with `host_we` high stores `host_wdata` at `host_addr`. A cycle with `host_re` high presents the word at `host_addr` on `rd_word` after the next rising clock edge.
- R3: `rd_word` keeps its value in every cycle in which no memory read is issued.
- R4: When sorting finishes, the table holds exactly the loaded words, duplicates included, in nondecreasing order from address 0 upward.
- R5: Let E0 be the edge at which the idle block first samples `sort_go` high. `sort_done` rises at edge E0+T, where T = 2(K-1) + 4·K(K-1)/2 + 4·S and S is the number of exchanges the i/j exchange sort makes on the loaded data.
- R6: `sort_done` stays high while `sort_go` stays high. It falls at the first edge that samples `sort_go` low, and load mode resumes after that edge.
- R7: Host writes and host reads have no effect from the cycle in which the idle block sees `sort_go` high until `sort_done` has fallen.
- R8: Equal words are never exchanged. Loading 3,2,1,3 gives 1,2,3,3 with S = 3, so T = 42 for K = 4.
- R9: After one complete sort, a new load and sort cycle works in the same way, with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wdata | input | N | Word the host writes in load mode |
| host_addr | input | L | Table address used for host writes and reads |
| host_we | input | 1 | Host write strobe, honoured only in load mode |
| sort_go | input | 1 | Mode bit: 0 is load/read, 1 requests a sort |
| host_re | input | 1 | Host read strobe, honoured only in load mode |
| rd_word | output | N | Registered memory read data |
| sort_done | output | 1 | High from the end of the sort until `sort_go` falls |

## Verification
A host write can arrive in the same cycle in which `sort_go` is first seen high, while the controller is still in its idle state. The same can happen during the `sort_done` interval, when the host still drives the port but no longer owns the memory. The bench provokes both cases by holding `host_we` high with a poison word at address 0 across the start edge, during the sort and while `sort_done` is high. It then judges the readback against the behavioural model: the poison word must never appear, and the table must be the sorted permutation of the loaded words. Because the model predicts `sort_done` edge-exactly from the exchange count, a stray write that alters the comparisons also shows up as a timing mismatch.

// File: rtl/xsort_pkg.sv
package xsort_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_I,
        ST_LD_I,
        ST_RD_J,
        ST_LD_J,
        ST_CMP,
        ST_WR_I,
        ST_WR_J,
        ST_RR_I,
        ST_RL_I,
        ST_NEXT,
        ST_DONE
    } st_e;

    // control bundle from controller to datapath and memory mux
    typedef struct packed {
        logic ld_i;    // clear outer index
        logic inc_i;   // advance outer index
        logic ld_j;    // load inner index with i+1
        logic inc_j;   // advance inner index
        logic cap_a;   // capture read data into A
        logic cap_b;   // capture read data into B
        logic sel_j;   // address from j (else i)
        logic wr_a;    // write data from A (else B)
        logic we;      // sorter write
        logic re;      // sorter read
        logic own;     // host may own memory
        logic done;    // sort finished
    } ctl_t;

endpackage

// File: rtl/xsort_mem.sv
module xsort_mem #(
    parameter int N = 8,
    parameter int L = 2,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         re,
    input  logic [L-1:0] addr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rdata
);
    localparam logic [L:0] DEPTH = (L+1)'(K);

    logic [N-1:0] store [K];
    logic [N-1:0] rdata_d, rdata_q;
    logic         in_range;

    assign in_range = ({1'b0, addr} < DEPTH);

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            store[addr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = in_range ? store[addr] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/xsort_dp.sv
module xsort_dp
    import xsort_pkg::*;
#(
    parameter int N = 8,
    parameter int L = 2,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctl_t         ctl,
    input  logic [N-1:0] rdata,
    output logic [L-1:0] i_idx,
    output logic [L-1:0] j_idx,
    output logic         i_last,
    output logic         j_last,
    output logic         a_gt_b,
    output logic [L-1:0] s_addr,
    output logic [N-1:0] s_wdata
);
    localparam logic [L-1:0] I_LAST = L'(K - 2);
    localparam logic [L-1:0] J_LAST = L'(K - 1);

    typedef struct packed {
        logic [L-1:0] i;
        logic [L-1:0] j;
        logic [N-1:0] a;
        logic [N-1:0] b;
    } dp_s;

    dp_s dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (ctl.ld_i)       dp_d.i = '0;
        else if (ctl.inc_i) dp_d.i = dp_q.i + 1'b1;
        if (ctl.ld_j)       dp_d.j = dp_q.i + 1'b1;
        else if (ctl.inc_j) dp_d.j = dp_q.j + 1'b1;
        if (ctl.cap_a)      dp_d.a = rdata;
        if (ctl.cap_b)      dp_d.b = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign i_idx   = dp_q.i;
    assign j_idx   = dp_q.j;
    assign i_last  = (dp_q.i == I_LAST);
    assign j_last  = (dp_q.j == J_LAST);
    assign a_gt_b  = (dp_q.a > dp_q.b);
    assign s_addr  = ctl.sel_j ? dp_q.j : dp_q.i;
    assign s_wdata = ctl.wr_a ? dp_q.a : dp_q.b;
endmodule

// File: rtl/xsort_ctrl.sv
module xsort_ctrl
    import xsort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic i_last,
    input  logic j_last,
    input  logic a_gt_b,
    output ctl_t ctl
);
    typedef struct packed {
        st_e st;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        ctl   = '0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                ctl.own = 1'b1;
                if (go) begin
                    ctl.ld_i    = 1'b1;
                    fsm_d.st    = ST_RD_I;
                end
            end
            ST_RD_I: begin
                ctl.re   = 1'b1;
                fsm_d.st = ST_LD_I;
            end
            ST_LD_I: begin
                ctl.cap_a = 1'b1;
                ctl.ld_j  = 1'b1;
                fsm_d.st  = ST_RD_J;
            end
            ST_RD_J: begin
                ctl.re    = 1'b1;
                ctl.sel_j = 1'b1;
                fsm_d.st  = ST_LD_J;
            end
            ST_LD_J: begin
                ctl.cap_b = 1'b1;
                fsm_d.st  = ST_CMP;
            end
            ST_CMP: begin
                fsm_d.st = a_gt_b ? ST_WR_I : ST_NEXT;
            end
            ST_WR_I: begin
                ctl.we   = 1'b1;
                fsm_d.st = ST_WR_J;
            end
            ST_WR_J: begin
                ctl.we    = 1'b1;
                ctl.sel_j = 1'b1;
                ctl.wr_a  = 1'b1;
                fsm_d.st  = ST_RR_I;
            end
            ST_RR_I: begin
                ctl.re   = 1'b1;
                fsm_d.st = ST_RL_I;
            end
            ST_RL_I: begin
                ctl.cap_a = 1'b1;
                fsm_d.st  = ST_NEXT;
            end
            ST_NEXT: begin
                if (!j_last) begin
                    ctl.inc_j = 1'b1;
                    fsm_d.st  = ST_RD_J;
                end else if (!i_last) begin
                    ctl.inc_i = 1'b1;
                    fsm_d.st  = ST_RD_I;
                end else begin
                    fsm_d.st  = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl.done = 1'b1;
                if (!go) fsm_d.st = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q.st <= ST_IDLE;
        else        fsm_q    <= fsm_d;
    end
endmodule

// File: rtl/xsort_top.sv
module xsort_top
    import xsort_pkg::*;
#(
    parameter int K = 4,
    parameter int N = 8,
    parameter int L = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] host_wdata,
    input  logic [L-1:0] host_addr,
    input  logic         host_we,
    input  logic         sort_go,
    input  logic         host_re,
    output logic [N-1:0] rd_word,
    output logic         sort_done
);
    initial begin
        if (K < 2 || K > (1 << L)) $error("xsort_top: K must lie in 2..2**L");
    end

    ctl_t         ctl;
    logic [L-1:0] i_idx, j_idx, s_addr;
    logic [N-1:0] s_wdata, rdata;
    logic         i_last, j_last, a_gt_b;
    logic         host_own, mem_we, mem_re;
    logic [L-1:0] mem_addr;
    logic [N-1:0] mem_wdata;

    xsort_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (sort_go),
        .i_last (i_last),
        .j_last (j_last),
        .a_gt_b (a_gt_b),
        .ctl    (ctl)
    );

    xsort_dp #(.N(N), .L(L), .K(K)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .rdata   (rdata),
        .i_idx   (i_idx),
        .j_idx   (j_idx),
        .i_last  (i_last),
        .j_last  (j_last),
        .a_gt_b  (a_gt_b),
        .s_addr  (s_addr),
        .s_wdata (s_wdata)
    );

    // host owns the memory only while idle and in load mode
    assign host_own  = ctl.own && !sort_go;
    assign mem_we    = host_own ? host_we    : ctl.we;
    assign mem_re    = host_own ? host_re    : ctl.re;
    assign mem_addr  = host_own ? host_addr  : s_addr;
    assign mem_wdata = host_own ? host_wdata : s_wdata;

    xsort_mem #(.N(N), .L(L), .K(K)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rdata)
    );

    assign rd_word   = rdata;
    assign sort_done = ctl.done;
endmodule

// File: rtl/xsort_chk.sv
module xsort_chk #(
    parameter int K = 4,
    parameter int N = 8,
    parameter int L = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         go,
    input logic         done,
    input logic         mem_we,
    input logic         mem_re,
    input logic [N-1:0] rdata,
    input logic         sel_j,
    input logic [L-1:0] i_idx,
    input logic [L-1:0] j_idx
);
    localparam logic [L-1:0] I_LAST = L'(K - 2);
    localparam logic [L-1:0] J_LAST = L'(K - 1);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go) |=> done);

    assert_done_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !go) |=> !done);

    assert_no_write_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    assert_hold_rdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> $stable(rdata));

    assert_i_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        i_idx <= I_LAST);

    assert_j_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_j |-> (j_idx > i_idx && j_idx <= J_LAST));
endmodule

bind xsort_top xsort_chk #(.K(K), .N(N), .L(L)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (sort_go),
    .done   (sort_done),
    .mem_we (mem_we),
    .mem_re (mem_re),
    .rdata  (rdata),
    .sel_j  (ctl.re && ctl.sel_j),
    .i_idx  (i_idx),
    .j_idx  (j_idx)
);

// File: tb/test_xsort_top.sv
module test_xsort_top;
    localparam int K = 4;
    localparam int N = 8;
    localparam int L = 2;
    localparam int POISON = 8'hEE;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] host_wdata = '0;
    logic [L-1:0] host_addr = '0;
    logic         host_we = 1'b0;
    logic         sort_go = 1'b0;
    logic         host_re = 1'b0;
    logic [N-1:0] rd_word;
    logic         sort_done;

    int n_cmp = 0;
    int n_bad = 0;

    // 250 MHz: 4 ns period
    always #2 clk = ~clk;

    xsort_top #(.K(K), .N(N), .L(L)) i_xsort_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wdata (host_wdata),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .sort_go    (sort_go),
        .host_re    (host_re),
        .rd_word    (rd_word),
        .sort_done  (sort_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mm [K];
    int mode = 0;          // 0 load, 1 sorting, 2 finished
    int cnt = 0;
    int tgt = 0;
    int exp_dout = 0;
    bit dout_known = 1'b1;
    bit last_rd = 1'b0;

    function automatic int model_sort();
        int swaps = 0;
        for (int i = 0; i < K - 1; i++) begin
            for (int j = i + 1; j < K; j++) begin
                if (mm[j] < mm[i]) begin
                    int t = mm[i];
                    mm[i] = mm[j];
                    mm[j] = t;
                    swaps++;
                end
            end
        end
        return 2 * (K - 1) + 4 * (K * (K - 1) / 2) + 4 * swaps;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0;
            exp_dout = 0;
            dout_known = 1'b1;
            last_rd = 1'b0;
        end else begin
            case (mode)
                0: begin
                    if (sort_go) begin
                        tgt = model_sort();
                        mode = 1;
                        cnt = 0;
                        dout_known = 1'b0;
                    end else begin
                        last_rd = host_re;
                        if (host_re) begin
                            exp_dout = mm[host_addr];
                            dout_known = 1'b1;
                        end
                        if (host_we) mm[host_addr] = int'(host_wdata);
                    end
                end
                1: begin
                    cnt++;
                    if (cnt == tgt) mode = 2;
                end
                default: if (!sort_go) mode = 0;
            endcase
        end
        #1;
        if (rst_n) begin
            check(sort_done == (mode == 2), (mode == 1) ? "R5 done timing" : "R6 done level",
                  int'(sort_done), int'(mode == 2));
            if (dout_known)
                check(int'(rd_word) == exp_dout, last_rd ? "R2 read data" : "R3 read hold",
                      int'(rd_word), exp_dout);
        end
    end

    // ---------------- host tasks ----------------
    task automatic do_wr(input int a, input int v);
        @(negedge clk);
        host_addr = L'(a);
        host_wdata = N'(v);
        host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic do_rd(input int a, output int v);
        @(negedge clk);
        host_addr = L'(a);
        host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        v = int'(rd_word);
    endtask

    task automatic run(input int vals [K], input int exp_lat, input string tag);
        int got [K];
        int ref_s [K];
        int c = 0;
        int v;
        for (int a = 0; a < K; a++) do_wr(a, vals[a]);
        do_rd(0, v);
        check(v == vals[0], "R2 readback before sort", v, vals[0]);
        @(negedge clk);
        check(int'(rd_word) == vals[0], "R3 hold when idle", int'(rd_word), vals[0]);
        // start with a poison write in the same cycle and during the sort (R7)
        @(negedge clk);
        sort_go = 1'b1;
        host_we = 1'b1;
        host_re = 1'b1;
        host_addr = '0;
        host_wdata = N'(POISON);
        while (c < 1000) begin
            @(negedge clk);
            c++;
            if (c == 3) begin
                host_we = 1'b0;
                host_re = 1'b0;
            end
            if (sort_done) break;
        end
        check(sort_done == 1'b1, "R5 done reached", int'(sort_done), 1);
        if (exp_lat >= 0) check(c - 1 == exp_lat, "R8 latency with equal words", c - 1, exp_lat);
        // poison write while finished, done must hold (R6, R7)
        host_we = 1'b1;
        repeat (3) @(negedge clk);
        check(sort_done == 1'b1, "R6 done held", int'(sort_done), 1);
        sort_go = 1'b0;
        @(negedge clk);
        host_we = 1'b0;
        check(sort_done == 1'b0, "R6 done released", int'(sort_done), 0);
        for (int a = 0; a < K; a++) do_rd(a, got[a]);
        for (int a = 0; a < K; a++) ref_s[a] = vals[a];
        ref_s.sort();
        for (int a = 1; a < K; a++)
            check(got[a - 1] <= got[a], "R4 nondecreasing", got[a], got[a - 1]);
        for (int a = 0; a < K; a++)
            check(got[a] == ref_s[a], {tag, " R4/R7 sorted permutation"}, got[a], ref_s[a]);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int p [K];
        repeat (3) @(negedge clk);
        check(sort_done == 1'b0, "R1 done in reset", int'(sort_done), 0);
        check(rd_word == '0, "R1 data in reset", int'(rd_word), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sort_done == 1'b0, "R1 done after reset", int'(sort_done), 0);
        check(rd_word == '0, "R1 data after reset", int'(rd_word), 0);

        p = '{3, 2, 1, 3};
        run(p, 42, "R8");
        p = '{200, 150, 90, 10};
        run(p, -1, "R9 reversed");
        p = '{5, 5, 5, 5};
        run(p, 30, "R9 all equal R8");
        p = '{1, 2, 3, 4};
        run(p, 30, "R9 presorted");
        for (int r = 0; r < 6; r++) begin
            for (int a = 0; a < K; a++) p[a] = int'($urandom % 256);
            run(p, -1, "R9 random");
        end
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule